// File: doc/BRIEF.md
# Transceiver Host SPI Slave with Register File and Frame Buffer

This block is the host-side port of a radio transceiver. A controller reaches it over a four-wire SPI link with an active-low select. Each select-low session carries exactly one transaction, and the first byte of the session is a command. The command either reads or writes one entry of a 64 x 8-bit register file, or moves a whole frame through a 128-byte frame buffer.

A frame upload sends a length byte followed by payload bytes. A frame download returns the stored length, then the payload, then one link-quality byte. The radio side loads the quality value through its own strobe. Raising select ends a session at any point, and the next session starts decoding afresh.

The SPI pins are oversampled by the block clock through synchronizers. SCLK must therefore stay low and high for at least four block-clock cycles per phase.

Top module: `xcvr_spi_slave`

## Requirements
- R1: After reset, MISO is 0, every register reads 0x00, and the stored frame length is 0.
- R2: While select is high, all session state is cleared, including a partly shifted byte; the next session treats its first full byte as a command.
- R3: SPI mode 0 applies, MSB first. While the command byte is shifted in, MISO returns 0x00.
- R4: Command 0b10aaaaaa (bits 7:6 = 10, bits 5:0 = address) returns the register at that address as the second byte of the session.
- R5: Command 0b11aaaaaa writes the second byte of the session into the register at that address. Bytes after the second are ignored: there is no write and MISO stays 0x00.
- R6: Command 0x60 is a frame upload. Byte 2 is the length, and only its low 7 bits are kept. Byte k (k >= 3) is stored at buffer index k-3. Bytes that would land at index 128 or above are dropped.
- R7: Command 0x20 is a frame download. Byte 2 returns the length (bit 7 = 0), and the following bytes return the buffer from index 0 upward, one byte per stored length unit.
- R8: In a download, the byte after the last payload byte returns the quality register, and every later byte returns 0x00.
- R9: A download may be stopped by raising select at any byte boundary, with no change to the length, the buffer or the registers.
- R10: Any other command is ignored: nothing is written, and MISO returns 0x00 for the rest of the session.
- R11: MISO changes only after a falling SCLK edge inside an active session, or when select is raised.
- R12: A pulse on `lqi_load` stores `lqi_value` into the quality register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_sel_n | input | 1 | Active-low session select |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| lqi_load | input | 1 | Radio-side strobe that loads the quality register |
| lqi_value | input | 8 | Quality value taken on `lqi_load` |

## Verification
A table of register write and read-back pairs is used to tell real address decoding apart from aliasing. It mixes the lowest and highest addresses, single-bit addresses and data with only the MSB or only the LSB set, which also exposes bit-order errors. Frame tests upload a short frame and a frame that overruns the buffer. The download is then read past its end, which separates the length byte, the payload, the quality byte and the zero fill. Sessions that are broken off after the length byte, in mid-payload or in mid-bit, together with unknown commands and extra bytes after a register write, show that none of these disturbs the stored state or the framing of the next session.

// File: rtl/xcvr_spi_pkg.sv
package xcvr_spi_pkg;

  // Session sequencing modes
  typedef enum logic [2:0] {
    M_CMD    = 3'd0,  // waiting for the command byte
    M_REG_RD = 3'd1,
    M_REG_WR = 3'd2,
    M_FB_WR  = 3'd3,
    M_FB_RD  = 3'd4,
    M_BAD    = 3'd5,  // unknown command, rest of session ignored
    M_DONE   = 3'd6   // register access finished, extra bytes ignored
  } sess_mode_e;

  // Source of the next outgoing byte in a frame download
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_LEN  = 2'd1,
    SRC_DATA = 2'd2,
    SRC_LQI  = 2'd3
  } rd_src_e;

  localparam logic [7:0] CMD_FRAME_UP   = 8'h60;
  localparam logic [7:0] CMD_FRAME_DOWN = 8'h20;

  function automatic sess_mode_e decode_cmd(input logic [7:0] c);
    if (c[7:6] == 2'b10) return M_REG_RD;
    if (c[7:6] == 2'b11) return M_REG_WR;
    if (c == CMD_FRAME_UP) return M_FB_WR;
    if (c == CMD_FRAME_DOWN) return M_FB_RD;
    return M_BAD;
  endfunction

endpackage

// File: rtl/xcvr_spi_phy.sv
module xcvr_spi_phy #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       sel_n,
  input  logic       mosi,
  input  logic [7:0] tx_next,
  output logic       sel_active,
  output logic       sclk_rise,
  output logic       sclk_fall,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso
);
  localparam int SM = SYNC_STAGES - 1;

  logic [SM:0] sclk_sync, seln_sync, mosi_sync;
  logic        sclk_d;
  logic [2:0]  bit_cnt;
  logic [6:0]  rx_sr;
  logic [7:0]  tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      seln_sync <= '1;
      mosi_sync <= '0;
      sclk_d    <= 1'b0;
    end else begin
      sclk_sync <= {sclk_sync[SM-1:0], sclk};
      seln_sync <= {seln_sync[SM-1:0], sel_n};
      mosi_sync <= {mosi_sync[SM-1:0], mosi};
      sclk_d    <= sclk_sync[SM];
    end
  end

  assign sel_active = ~seln_sync[SM];
  assign sclk_rise  = sel_active & sclk_sync[SM] & ~sclk_d;
  assign sclk_fall  = sel_active & ~sclk_sync[SM] & sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      rx_byte   <= '0;
      tx_sr     <= '0;
      byte_done <= 1'b0;
    end else if (!sel_active) begin
      bit_cnt   <= '0;
      tx_sr     <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (sclk_rise) begin
        rx_sr   <= {rx_sr[5:0], mosi_sync[SM]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          rx_byte   <= {rx_sr, mosi_sync[SM]};
        end
      end
      if (sclk_fall) begin
        // first falling edge of a byte loads it, later ones shift
        tx_sr <= (bit_cnt == 3'd0) ? tx_next : {tx_sr[6:0], 1'b0};
      end
    end
  end

  assign miso = tx_sr[7];
endmodule

// File: rtl/xcvr_spi_regfile.sv
module xcvr_spi_regfile #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/xcvr_spi_framebuf.sv
module xcvr_spi_framebuf #(
  parameter int FB_DEPTH = 128,
  localparam int FB_AW = $clog2(FB_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [FB_AW-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [FB_AW-1:0] raddr,
  output logic [7:0]       rdata,
  input  logic             len_we,
  input  logic [FB_AW-1:0] len_wdata,
  output logic [FB_AW-1:0] len,
  input  logic             lqi_we,
  input  logic [7:0]       lqi_wdata,
  output logic [7:0]       lqi
);
  logic [7:0] mem [FB_DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len <= '0;
      lqi <= '0;
    end else begin
      if (len_we) len <= len_wdata;
      if (lqi_we) lqi <= lqi_wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/xcvr_spi_seq.sv
module xcvr_spi_seq
  import xcvr_spi_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int FB_DEPTH = 128,
  localparam int FB_AW = $clog2(FB_DEPTH),
  localparam int IDX_W = FB_AW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_active,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  input  logic [7:0]        reg_rdata,
  input  logic [7:0]        fb_rdata,
  input  logic [FB_AW-1:0]  fb_len,
  input  logic [7:0]        fb_lqi,
  output sess_mode_e        mode,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_we,
  output logic              fb_we,
  output logic [FB_AW-1:0]  fb_waddr,
  output logic [FB_AW-1:0]  fb_raddr,
  output logic              len_we,
  output logic [7:0]        tx_next
);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_TWO = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(FB_DEPTH + 2);

  // which byte goes out at session byte number i of a frame download
  function automatic rd_src_e pick_src(input logic [IDX_W-1:0] i,
                                       input logic [FB_AW-1:0] l);
    logic [IDX_W-1:0] last;
    last = IDX_W'(l) + IDX_TWO;
    if (i == IDX_ONE) return SRC_LEN;
    if (i >= IDX_TWO && i < last) return SRC_DATA;
    if (i == last) return SRC_LQI;
    return SRC_ZERO;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= M_CMD;
      idx      <= '0;
      reg_addr <= '0;
    end else if (!sel_active) begin
      mode <= M_CMD;
      idx  <= '0;
    end else if (byte_done) begin
      idx <= (idx == '1) ? idx : idx + IDX_ONE;
      case (mode)
        M_CMD: begin
          mode     <= decode_cmd(rx_byte);
          reg_addr <= rx_byte[ADDR_W-1:0];
        end
        M_REG_RD, M_REG_WR: mode <= M_DONE;
        default: ;
      endcase
    end
  end

  assign reg_we   = byte_done && (mode == M_REG_WR);
  assign len_we   = byte_done && (mode == M_FB_WR) && (idx == IDX_ONE);
  assign fb_we    = byte_done && (mode == M_FB_WR) && (idx >= IDX_TWO) && (idx < IDX_END);
  assign fb_waddr = FB_AW'(idx - IDX_TWO);
  assign fb_raddr = FB_AW'(idx - IDX_TWO);

  always_comb begin
    tx_next = '0;
    case (mode)
      M_REG_RD: if (idx == IDX_ONE) tx_next = reg_rdata;
      M_FB_RD: begin
        case (pick_src(idx, fb_len))
          SRC_LEN:  tx_next = 8'(fb_len);
          SRC_DATA: tx_next = fb_rdata;
          SRC_LQI:  tx_next = fb_lqi;
          default:  tx_next = '0;
        endcase
      end
      default: tx_next = '0;
    endcase
  end
endmodule

// File: rtl/xcvr_spi_slave.sv
module xcvr_spi_slave
  import xcvr_spi_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int FB_DEPTH    = 128,
  parameter int SYNC_STAGES = 2,
  localparam int FB_AW = $clog2(FB_DEPTH),
  localparam int IDX_W = FB_AW + 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_sel_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic       lqi_load,
  input  logic [7:0] lqi_value
);
  logic              sel_active, sclk_rise, sclk_fall, byte_done;
  logic [7:0]        rx_byte, tx_next, reg_rdata, fb_rdata, fb_lqi;
  sess_mode_e        seq_mode;
  logic [IDX_W-1:0]  seq_idx;
  logic [ADDR_W-1:0] reg_addr;
  logic              reg_we, fb_we, len_we;
  logic [FB_AW-1:0]  fb_waddr, fb_raddr, fb_len;

  xcvr_spi_phy #(.SYNC_STAGES(SYNC_STAGES)) u_phy (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .sel_n(spi_sel_n),
    .mosi(spi_mosi), .tx_next(tx_next), .sel_active(sel_active),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .byte_done(byte_done),
    .rx_byte(rx_byte), .miso(spi_miso)
  );

  xcvr_spi_seq #(.ADDR_W(ADDR_W), .FB_DEPTH(FB_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .sel_active(sel_active), .byte_done(byte_done),
    .rx_byte(rx_byte), .reg_rdata(reg_rdata), .fb_rdata(fb_rdata),
    .fb_len(fb_len), .fb_lqi(fb_lqi), .mode(seq_mode), .idx(seq_idx),
    .reg_addr(reg_addr), .reg_we(reg_we), .fb_we(fb_we), .fb_waddr(fb_waddr),
    .fb_raddr(fb_raddr), .len_we(len_we), .tx_next(tx_next)
  );

  xcvr_spi_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(rx_byte), .rdata(reg_rdata)
  );

  xcvr_spi_framebuf #(.FB_DEPTH(FB_DEPTH)) u_fbuf (
    .clk(clk), .rst_n(rst_n), .we(fb_we), .waddr(fb_waddr), .wdata(rx_byte),
    .raddr(fb_raddr), .rdata(fb_rdata), .len_we(len_we),
    .len_wdata(rx_byte[FB_AW-1:0]), .len(fb_len), .lqi_we(lqi_load),
    .lqi_wdata(lqi_value), .lqi(fb_lqi)
  );
endmodule

// File: rtl/xcvr_spi_slave_chk.sv
module xcvr_spi_slave_chk
  import xcvr_spi_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_active,
  input logic             sclk_fall,
  input logic             spi_miso,
  input sess_mode_e       seq_mode,
  input logic [IDX_W-1:0] seq_idx,
  input logic             reg_we,
  input logic             fb_we,
  input logic             len_we
);
  p_idle_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_active |=> (seq_idx == '0 && seq_mode == M_CMD));

  p_cmd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_active && seq_idx == '0) |-> !spi_miso);

  p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (seq_mode == M_DONE && !reg_we));

  p_read_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode == M_FB_RD || seq_mode == M_REG_RD) |-> !(fb_we || len_we || reg_we));

  p_bad_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode == M_BAD) |-> (!spi_miso && !fb_we && !len_we && !reg_we));

  p_miso_fall_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_active && $past(sel_active) && !$past(sclk_fall)) |-> $stable(spi_miso));
endmodule

bind xcvr_spi_slave xcvr_spi_slave_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_active(sel_active), .sclk_fall(sclk_fall),
  .spi_miso(spi_miso), .seq_mode(seq_mode), .seq_idx(seq_idx),
  .reg_we(reg_we), .fb_we(fb_we), .len_we(len_we)
);

// File: tb/test_xcvr_spi_slave.sv
`timescale 1ns/1ps
module test_xcvr_spi_slave;
  localparam int HALF = 6;  // block clocks per SCLK phase

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_sel_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic lqi_load = 1'b0;
  logic [7:0] lqi_value = '0;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xcvr_spi_slave i_xcvr_spi_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_sel_n(spi_sel_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .lqi_load(lqi_load),
    .lqi_value(lqi_value)
  );

  // {address[5:0], data[7:0]}
  localparam logic [13:0] VEC [6] = '{
    {6'h00, 8'h5A}, {6'h3F, 8'hC3}, {6'h15, 8'h01},
    {6'h2A, 8'h80}, {6'h01, 8'hFF}, {6'h20, 8'h7E}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      spi_mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic open_s();
    @(negedge clk) spi_sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic close_s();
    repeat (HALF) @(negedge clk);
    spi_sel_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] r;
    open_s(); xfer({2'b11, a}, r); xfer(d, r); close_s();
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [7:0] d, output logic [7:0] c);
    open_s(); xfer({2'b10, a}, c); xfer(8'h00, d); close_s();
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  initial begin
    logic [7:0] r, c;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 miso idle", {7'd0, spi_miso}, 8'h00);
    reg_rd(6'h10, r, c);
    check("R1 register reset", r, 8'h00);
    open_s(); xfer(8'h20, c); xfer(8'h00, r); close_s();
    check("R1 frame length reset", r, 8'h00);

    // R4/R5: table of write / read-back pairs
    foreach (VEC[i]) reg_wr(VEC[i][13:8], VEC[i][7:0]);
    foreach (VEC[i]) begin
      reg_rd(VEC[i][13:8], r, c);
      check("R3 command byte miso", c, 8'h00);
      check("R4 R5 read back", r, VEC[i][7:0]);
    end

    // R5: bytes after the data byte are ignored
    open_s(); xfer(8'hC5, r); xfer(8'h99, r); xfer(8'h44, r);
    check("R5 extra byte miso", r, 8'h00);
    close_s();
    reg_rd(6'h05, r, c); check("R5 written value", r, 8'h99);
    reg_rd(6'h06, r, c); check("R5 no spill to next address", r, 8'h00);

    // R10: unknown commands
    open_s(); xfer(8'h05, c); xfer(8'hEE, r);
    check("R10 miso after bad cmd", r, 8'h00);
    xfer(8'h11, r); check("R10 miso later byte", r, 8'h00);
    close_s();
    open_s(); xfer(8'h61, c); xfer(8'h03, r); xfer(8'h77, r); close_s();
    reg_rd(6'h05, r, c); check("R10 register untouched", r, 8'h99);
    open_s(); xfer(8'h20, c); xfer(8'h00, r); close_s();
    check("R10 length untouched", r, 8'h00);

    // R12: quality value from the radio side
    @(negedge clk) begin lqi_load = 1'b1; lqi_value = 8'hB7; end
    @(negedge clk) lqi_load = 1'b0;

    // R6/R7/R8: short frame round trip
    open_s(); xfer(8'h60, r); xfer(8'h05, r);
    for (int i = 0; i < 5; i++) xfer(8'h11 * 8'(i + 1), r);
    close_s();
    open_s(); xfer(8'h20, c);
    check("R3 frame command miso", c, 8'h00);
    xfer(8'h00, r); check("R7 length byte", r, 8'h05);
    for (int i = 0; i < 5; i++) begin
      xfer(8'h00, r); check("R7 payload", r, 8'h11 * 8'(i + 1));
    end
    xfer(8'h00, r); check("R8 R12 quality byte", r, 8'hB7);
    xfer(8'h00, r); check("R8 zero after quality", r, 8'h00);
    xfer(8'h00, r); check("R8 zero fill", r, 8'h00);
    close_s();

    // R9: early abort after length, and in mid-payload
    open_s(); xfer(8'h20, c); xfer(8'h00, r); close_s();
    check("R9 length only", r, 8'h05);
    open_s(); xfer(8'h20, c); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h00, r); close_s();
    check("R9 second payload", r, 8'h22);
    open_s(); xfer(8'h20, c); xfer(8'h00, r);
    check("R9 length after aborts", r, 8'h05);
    for (int i = 0; i < 5; i++) begin
      xfer(8'h00, r); check("R9 payload after aborts", r, 8'h11 * 8'(i + 1));
    end
    close_s();

    // R2: session broken off in mid-byte
    open_s();
    for (int b = 0; b < 3; b++) begin
      spi_mosi = 1'b1;
      repeat (HALF) @(negedge clk); spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk); spi_sclk = 1'b0;
    end
    close_s();
    reg_rd(6'h00, r, c);
    check("R2 fresh decode after partial byte", r, 8'h5A);
    check("R2 command miso after partial", c, 8'h00);

    // R6: oversized frame, length 0xFF and 130 payload bytes
    open_s(); xfer(8'h60, r); xfer(8'hFF, r);
    for (int i = 0; i < 130; i++) xfer(pat(i), r);
    close_s();
    open_s(); xfer(8'h20, c); xfer(8'h00, r);
    check("R6 length low 7 bits", r, 8'h7F);
    for (int i = 0; i < 127; i++) begin
      xfer(8'h00, r); check("R6 payload no wrap", r, pat(i));
    end
    xfer(8'h00, r); check("R8 quality after long frame", r, 8'hB7);
    close_s();
    reg_rd(6'h3F, r, c); check("R6 registers untouched", r, 8'hC3);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule